// File: doc/BRIEF.md
# Router Input Port Flit Controller

This block is the control logic attached to one input port of a five-output mesh router with no virtual channels. It reads the 8-bit header of the flit at the front of the input queue and works out the flit's kind and its destination. When a new message opens with a head flit, the block routes the destination coordinates to one of five outputs and stores that output index for the rest of the message. It requests the output from the arbiter and, once granted, keeps the output reserved against the other inputs until the message's last flit has been granted.

The controller is a three-state machine. **IDLE** means no message is open. The transition *accept_head* (a valid head flit at the front) latches the routed port and moves to **CLAIM**. In IDLE any other valid flit takes the transition *drop_stray*: it is popped and no request is raised. In **CLAIM** the block requests the stored port, unless another input reserves that port. The transition *win_port* (request and grant in the same cycle) pops the head and enters **OPEN**. In OPEN, body and tail flits request the reserved port. A granted body flit stays in OPEN. A granted tail flit takes the transition *close_msg* back to IDLE. Unused flits and extra head flits met in OPEN are popped without a request (*drop_stray*).

The neighbouring logic sees the reservation as a one-hot vector and ORs it with the vectors of the other inputs. That OR gives the `others_hold` input of each controller. The `pop` output releases the front entry of the input queue.

Top module: `in_port_state_ctl`

## Requirements
- R1: Header bits [7:6] hold the flit kind and bits [5:0] hold the destination. The kind codes are 2'b11 head, 2'b10 body, 2'b01 tail and 2'b00 unused.
- R2: The destination splits into X = bits [5:3] and Y = bits [2:0]. With the router placed at (3,3), the routed port is chosen in this priority order: X>3 gives port 0, X<3 gives port 1, Y>3 gives port 2, Y<3 gives port 3, and otherwise port 4 (local).
- R3: `port_addr` resets to 0. It changes only in the cycle after a valid head flit is seen in IDLE, and then takes that head's routed port.
- R4: `req` is either zero or the one-hot of `port_addr`. It is raised only when `buf_valid` is high and either the state is CLAIM, or the state is OPEN and the flit is a body or tail.
- R5: In CLAIM, while `others_hold[port_addr]` is high, `req` stays low and the head is not popped. The request is raised in the first cycle after that bit clears.
- R6: `hold` is the one-hot of `port_addr` from the cycle after the head's grant until the cycle of the tail's grant, inclusive. It is zero in the cycle after the tail's grant and at all other times.
- R7: With no message open, valid body, tail and unused flits are popped in the same cycle with no request. With a message open, valid unused and head flits are also popped with no request.
- R8: A grant that arrives while `req` is zero has no effect on `pop`, the state or `hold`.
- R9: `pop` is high in any cycle where a request is raised and `grant` is high.
- R10: While reset is asserted and after it is released, the block is in IDLE with `req`, `hold` and `port_addr` at zero. `pop` stays low as long as `buf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr | input | 8 | Header of the flit at the front of the input queue |
| buf_valid | input | 1 | The input queue front holds a flit |
| grant | input | 1 | The arbiter grants this input's current request |
| others_hold | input | 5 | Per-output reservations held by the other inputs |
| req | output | 5 | One-hot request toward the arbiter of an output |
| pop | output | 1 | Front flit is consumed (crossed or dropped) |
| port_addr | output | 3 | Stored output index of the open message |
| hold | output | 5 | One-hot reservation held by this input |

## Verification
The assertions take three things for granted about the inputs. The queue front does not change or lose its valid flag until `pop` is seen. `others_hold` never marks the output this input itself reserves. `grant` is only meaningful alongside a request. The stimulus keeps to this by replacing the front flit only after a pop or an empty cycle, and by masking the reserved port out of the random `others_hold` pattern while a message is open. Grants are still toggled at random in cycles with no request, to exercise R8.

// File: rtl/router_ctl_pkg.sv
package router_ctl_pkg;

    localparam int KIND_W = 2;
    localparam int DEST_W = 6;
    localparam int HDR_W  = KIND_W + DEST_W;

    typedef enum logic [KIND_W-1:0] {
        FK_UNUSED = 2'b00,
        FK_TAIL   = 2'b01,
        FK_BODY   = 2'b10,
        FK_HEAD   = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_OPEN  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/flit_hdr_split.sv
module flit_hdr_split
    import router_ctl_pkg::*;
#(
    parameter int H_W = HDR_W,
    parameter int K_W = KIND_W,
    parameter int D_W = H_W - K_W
) (
    input  logic [H_W-1:0] hdr,
    output flit_kind_e     kind,
    output logic [D_W-1:0] dest
);
    // Kind code sits in the top bits, destination below it.
    assign kind = flit_kind_e'(hdr[H_W-1 -: K_W]);
    assign dest = hdr[D_W-1:0];
endmodule

// File: rtl/xy_route_lut.sv
module xy_route_lut #(
    parameter int D_W     = 6,
    parameter int HOME_X  = 3,
    parameter int HOME_Y  = 3,
    parameter int PIDX_W  = 3,
    localparam int C_W    = D_W / 2
) (
    input  logic [D_W-1:0]    dest,
    output logic [PIDX_W-1:0] port
);
    localparam logic [C_W-1:0] HX = C_W'(HOME_X);
    localparam logic [C_W-1:0] HY = C_W'(HOME_Y);

    logic [C_W-1:0] dx;
    logic [C_W-1:0] dy;

    assign dx = dest[D_W-1 -: C_W];
    assign dy = dest[C_W-1:0];

    // Dimension-ordered table: X resolved first, then Y, then local.
    always_comb begin
        if (dx > HX)      port = PIDX_W'(0);
        else if (dx < HX) port = PIDX_W'(1);
        else if (dy > HY) port = PIDX_W'(2);
        else if (dy < HY) port = PIDX_W'(3);
        else              port = PIDX_W'(4);
    end
endmodule

// File: rtl/port_onehot.sv
module port_onehot #(
    parameter int NPORT  = 5,
    parameter int PIDX_W = 3
) (
    input  logic [PIDX_W-1:0] idx,
    output logic [NPORT-1:0]  vec
);
    for (genvar i = 0; i < NPORT; i++) begin : g_bit
        assign vec[i] = (idx == PIDX_W'(i));
    end
endmodule

// File: rtl/in_port_state_ctl.sv
module in_port_state_ctl
    import router_ctl_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int H_W    = HDR_W,
    parameter int K_W    = KIND_W,
    parameter int HOME_X = 3,
    parameter int HOME_Y = 3,
    localparam int D_W    = H_W - K_W,
    localparam int PIDX_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    hdr,
    input  logic              buf_valid,
    input  logic              grant,
    input  logic [NPORT-1:0]  others_hold,
    output logic [NPORT-1:0]  req,
    output logic              pop,
    output logic [PIDX_W-1:0] port_addr,
    output logic [NPORT-1:0]  hold
);
    ctl_state_e        state_q, state_d;
    logic [PIDX_W-1:0] port_q;
    logic [PIDX_W-1:0] lut_port;
    logic [NPORT-1:0]  port_vec;
    flit_kind_e        kind;
    logic [D_W-1:0]    dest;
    logic              blocked;
    logic              req_en;
    logic              latch_port;
    logic              is_payload;

    flit_hdr_split #(.H_W(H_W), .K_W(K_W), .D_W(D_W)) u_split (
        .hdr  (hdr),
        .kind (kind),
        .dest (dest)
    );

    xy_route_lut #(
        .D_W(D_W), .HOME_X(HOME_X), .HOME_Y(HOME_Y), .PIDX_W(PIDX_W)
    ) u_lut (
        .dest (dest),
        .port (lut_port)
    );

    port_onehot #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_onehot (
        .idx (port_q),
        .vec (port_vec)
    );

    assign blocked    = |(others_hold & port_vec);
    assign is_payload = (kind == FK_BODY) || (kind == FK_TAIL);
    assign latch_port = (state_q == ST_IDLE) && buf_valid && (kind == FK_HEAD);

    // State and stored port register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            if (latch_port) port_q <= lut_port;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (latch_port) state_d = ST_CLAIM;
            end
            ST_CLAIM: begin
                if (buf_valid && !blocked && grant) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (buf_valid && grant && (kind == FK_TAIL)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        req_en = 1'b0;
        pop    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pop = buf_valid && (kind != FK_HEAD);
            end
            ST_CLAIM: begin
                req_en = buf_valid && !blocked;
                pop    = buf_valid && !blocked && grant;
            end
            ST_OPEN: begin
                req_en = buf_valid && is_payload;
                pop    = buf_valid && (!is_payload || grant);
            end
            default: begin
                req_en = 1'b0;
                pop    = 1'b0;
            end
        endcase
    end

    assign req       = port_vec & {NPORT{req_en}};
    assign hold      = port_vec & {NPORT{state_q == ST_OPEN}};
    assign port_addr = port_q;

endmodule

// File: rtl/in_port_state_ctl_chk.sv
module in_port_state_ctl_chk #(
    parameter int NPORT  = 5,
    parameter int PIDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        flit_id,
    input logic              buf_valid,
    input logic              grant,
    input logic [NPORT-1:0]  others_hold,
    input logic [NPORT-1:0]  req,
    input logic              pop,
    input logic [PIDX_W-1:0] port_addr,
    input logic [NPORT-1:0]  hold
);
    assert_req_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    assert_req_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_valid |-> (req == '0));

    assert_req_on_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (req == (NPORT'(1) << port_addr)));

    assert_no_req_when_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req & others_hold) == '0);

    assert_hold_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hold));

    assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold != '0) && !(grant && (req != '0) && (flit_id == 2'b01)))
        |=> (hold == $past(hold)));

    assert_port_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold != '0) |=> $stable(port_addr));

    assert_unused_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && (flit_id == 2'b00)) |-> (req == '0));

    assert_pop_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> buf_valid);

    assert_grant_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req != '0)) |-> pop);

endmodule

bind in_port_state_ctl in_port_state_ctl_chk #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_id     (hdr[H_W-1 -: 2]),
    .buf_valid   (buf_valid),
    .grant       (grant),
    .others_hold (others_hold),
    .req         (req),
    .pop         (pop),
    .port_addr   (port_addr),
    .hold        (hold)
);

// File: tb/sim_in_port_state_ctl.sv
module sim_in_port_state_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hdr = '0;
    logic       buf_valid = 1'b0;
    logic       grant = 1'b0;
    logic [4:0] others_hold = '0;
    logic [4:0] req;
    logic       pop;
    logic [2:0] port_addr;
    logic [4:0] hold;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model state: 0 idle, 1 claim, 2 open
    int         m_st = 0;
    logic [2:0] m_port = '0;
    int         n_st;
    logic [2:0] n_port;
    logic       e_pop;

    in_port_state_ctl u0 (
        .clk(clk), .rst_n(rst_n), .hdr(hdr), .buf_valid(buf_valid),
        .grant(grant), .others_hold(others_hold), .req(req), .pop(pop),
        .port_addr(port_addr), .hold(hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2:0] route(input logic [5:0] d);
        logic [2:0] x, y;
        x = d[5:3];
        y = d[2:0];
        if (x > 3'd3)      return 3'd0;
        else if (x < 3'd3) return 3'd1;
        else if (y > 3'd3) return 3'd2;
        else if (y < 3'd3) return 3'd3;
        else               return 3'd4;
    endfunction

    function automatic logic [4:0] onehot(input logic [2:0] p);
        return 5'(1) << p;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare at mid-cycle, advance the model at the edge.
    task automatic step(input logic v, input logic [7:0] h, input logic g, input logic [4:0] oh);
        logic [1:0] k;
        logic [4:0] e_req;
        @(negedge clk);
        buf_valid = v; hdr = h; grant = g; others_hold = oh;
        #2;
        k = h[7:6];
        e_req = '0; e_pop = 1'b0; n_st = m_st; n_port = m_port;
        case (m_st)
            0: if (v) begin
                   if (k == 2'b11) begin n_st = 1; n_port = route(h[5:0]); end
                   else e_pop = 1'b1;
               end
            1: if (v && !oh[m_port]) begin
                   e_req = onehot(m_port);
                   if (g) begin e_pop = 1'b1; n_st = 2; end
               end
            default: if (v) begin
                   if (k == 2'b10 || k == 2'b01) begin
                       e_req = onehot(m_port);
                       if (g) begin e_pop = 1'b1; if (k == 2'b01) n_st = 0; end
                   end else e_pop = 1'b1;
               end
        endcase
        chk("R1 R4 R5 req", 8'(req), 8'(e_req));
        chk("R7 R8 R9 pop", 8'(pop), 8'(e_pop));
        chk("R2 R3 port_addr", 8'(port_addr), 8'(m_port));
        chk("R6 hold", 8'(hold), (m_st == 2) ? 8'(onehot(m_port)) : 8'h00);
        @(posedge clk);
        m_st = n_st; m_port = n_port;
    endtask

    function automatic logic [7:0] rand_flit();
        int r;
        logic [1:0] k;
        r = int'($urandom % 20);
        if (r < 6)       k = 2'b11;
        else if (r < 13) k = 2'b10;
        else if (r < 18) k = 2'b01;
        else             k = 2'b00;
        return {k, 6'($urandom)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic       v;
        logic [7:0] h;
        logic [4:0] oh;
        logic       have;
        void'($urandom(32'd1234));
        // R10: reset state
        #3;
        chk("R10 req in reset", 8'(req), 8'h00);
        chk("R10 hold in reset", 8'(hold), 8'h00);
        chk("R10 pop in reset", 8'(pop), 8'h00);
        chk("R10 port in reset", 8'(port_addr), 8'h00);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b1, 5'b00000);           // R8/R10 idle, grant ignored
        // R7 strays in idle
        step(1'b1, {2'b00, 6'o12}, 1'b1, 5'b0);
        step(1'b1, {2'b01, 6'o33}, 1'b0, 5'b0);
        step(1'b1, {2'b10, 6'o33}, 1'b1, 5'b0);
        // R2/R5 head to east, blocked, grant while blocked ignored (R8)
        step(1'b1, {2'b11, 6'o53}, 1'b0, 5'b00001);
        step(1'b1, {2'b11, 6'o53}, 1'b1, 5'b00001);
        step(1'b1, {2'b11, 6'o53}, 1'b0, 5'b00001);
        step(1'b1, {2'b11, 6'o53}, 1'b0, 5'b00000);  // R5 request appears
        step(1'b1, {2'b11, 6'o53}, 1'b1, 5'b00000);  // R9 win
        step(1'b1, {2'b10, 6'o00}, 1'b0, 5'b11110);  // R6 held, body waits
        step(1'b1, {2'b10, 6'o00}, 1'b1, 5'b11110);
        step(1'b1, {2'b00, 6'o00}, 1'b1, 5'b0);      // R7 unused in open
        step(1'b1, {2'b11, 6'o33}, 1'b0, 5'b0);      // R7 stray head in open
        step(1'b1, {2'b01, 6'o00}, 1'b1, 5'b0);      // tail closes
        step(1'b0, 8'h00, 1'b0, 5'b0);               // R6 hold cleared
        // R2 local and the other directions
        step(1'b1, {2'b11, 6'o33}, 1'b0, 5'b0);
        step(1'b1, {2'b11, 6'o33}, 1'b1, 5'b0);
        step(1'b1, {2'b01, 6'o00}, 1'b1, 5'b0);
        step(1'b1, {2'b11, 6'o34}, 1'b0, 5'b0);
        step(1'b1, {2'b11, 6'o34}, 1'b1, 5'b0);
        step(1'b1, {2'b01, 6'o00}, 1'b1, 5'b0);
        // Random traffic
        have = 1'b0; h = '0; oh = '0; v = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (!have) begin
                v = ($urandom % 4) != 0;
                h = rand_flit();
            end
            if (($urandom % 4) == 0) oh = 5'($urandom);
            if (m_st == 2) oh[m_port] = 1'b0;
            step(v, h, 1'($urandom % 2), oh);
            have = v && !e_pop;
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule